// File: doc/BRIEF.md
# Dual-Channel Simultaneous Conversion Sequencer

This block controls a converter that freezes two analog channels at the same instant and then converts them one after the other. A falling edge on the active-low start input puts both track-and-hold stages into hold. The same edge latches which input pair is converted. The sequencer then times channel A's conversion, a short separation gap and channel B's conversion, all counted in system clock cycles. It drives a busy window that covers the whole sequence and an end-of-conversion level that is high during each channel's conversion.

Both 16-bit codes are moved into a 32-bit result register together, on the cycle busy drops. A read therefore never mixes channels taken at different instants. A behavioural result generator stands in for the analog converter: each held sample is returned as its ideal code. A reduced-power mode lengthens channel A's conversion and adds a level-triggered start at the end of acquisition. A synchronous abort input and a power-down input complete the control set.

Top module: `dual_conv_seq`

## Requirements
- R1: A falling edge on start_ni, seen while the block is idle and neither pwr_down_i nor abort_i is high, makes busy_o and eoc_o high in the next cycle.
- R2: A conversion holds busy_o high for exactly A+GAP_CYC+B_CYC cycles. During that window eoc_o is high for A cycles, then low for GAP_CYC cycles, then high for B_CYC cycles. eoc_o is never high while busy_o is low.
- R3: A is A_NM_CYC when low_pwr_i is low at the start and A_LP_CYC when it is high. Changing low_pwr_i after the start has no effect on the running conversion.
- R4: pair_sel_i sampled at the start selects the pair: 0 converts ain_a1_i/ain_b1_i and 1 converts ain_a2_i/ain_b2_i. When the conversion completes, result_o[31:16] holds channel A's code, result_o[15:0] holds channel B's code, and pair_o holds the selected pair.
- R5: The analog inputs and pair_sel_i are frozen at the start. Changes to them after the start do not alter the result.
- R6: result_o and pair_o change only in the cycle in which busy_o falls at the end of a completed conversion.
- R7: Start edges that arrive while busy_o is high, or during the ACQ_CYC-cycle acquisition phase that follows, are ignored.
- R8: In reduced-power mode, a start input still held low at the end of acquisition starts a new conversion exactly ACQ_CYC cycles after busy_o fell, with no new edge. In normal mode a held-low start does nothing.
- R9: abort_i high returns the block to idle in the next cycle: busy_o and eoc_o go low and the result register keeps its previous value. A later start edge runs normally.
- R10: pwr_down_i high blocks new conversions. A conversion already running completes and loads its result.
- R11: After rst_ni, busy_o, eoc_o, result_o and pair_o are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| abort_i | input | 1 | Synchronous abort of any conversion, active high |
| pwr_down_i | input | 1 | Blocks new conversions, active high |
| low_pwr_i | input | 1 | Reduced-power mode select |
| start_ni | input | 1 | Start, falling-edge (or held-low level in reduced-power mode) |
| pair_sel_i | input | 1 | Input pair select, latched at start |
| ain_a1_i | input | 16 | Channel A, pair 1 sample value |
| ain_a2_i | input | 16 | Channel A, pair 2 sample value |
| ain_b1_i | input | 16 | Channel B, pair 1 sample value |
| ain_b2_i | input | 16 | Channel B, pair 2 sample value |
| busy_o | output | 1 | High from start until both results are latched |
| eoc_o | output | 1 | High while a channel conversion runs |
| result_o | output | 32 | {channel A code, channel B code} |
| pair_o | output | 1 | Pair that produced result_o |

## Verification
The assertions check on every cycle that eoc_o never rises outside the busy window and that busy only rises from idle or at the end of acquisition. They also check that abort and power-down gate the busy flag, that busy always ends from an active channel conversion, and that the result register stays put except on a load. The exact phase lengths of each mode need the directed scenarios. So do the pair selection, the freezing of inputs at the start edge, the ignored edges during busy and acquisition, and the level-triggered restart after exactly ACQ_CYC cycles. Each scenario compares the counted eoc/busy profile and the loaded result against values computed from the requirements.

// File: rtl/dual_conv_pkg.sv
package dual_conv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONV_A,
    ST_GAP,
    ST_CONV_B,
    ST_ACQ
  } phase_e;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/dcs_start_qual.sv
module dcs_start_qual (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_ni,
  output logic fall_o,
  output logic low_o
);
  logic start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) start_q <= 1'b1;
    else         start_q <= start_ni;
  end

  assign fall_o = start_q & ~start_ni;
  assign low_o  = ~start_ni;
endmodule

// File: rtl/dcs_phase_ctrl.sv
module dcs_phase_ctrl
  import dual_conv_pkg::*;
#(
  parameter int unsigned A_NM_CYC = 196,
  parameter int unsigned A_LP_CYC = 246,
  parameter int unsigned GAP_CYC  = 4,
  parameter int unsigned B_CYC    = 150,
  parameter int unsigned ACQ_CYC  = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic abort_i,
  input  logic pwr_down_i,
  input  logic low_pwr_i,
  input  logic fall_i,
  input  logic low_i,
  output logic capture_o,
  output logic a_done_o,
  output logic b_done_o,
  output logic busy_o,
  output logic eoc_o
);
  localparam int unsigned MAX_LEN = max2(max2(A_NM_CYC, A_LP_CYC),
                                         max2(max2(GAP_CYC, B_CYC), ACQ_CYC));
  localparam int unsigned CNT_W = (MAX_LEN > 2) ? $clog2(MAX_LEN) : 1;
  localparam logic [CNT_W-1:0] A_NM_L = CNT_W'(A_NM_CYC - 1);
  localparam logic [CNT_W-1:0] A_LP_L = CNT_W'(A_LP_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_L  = CNT_W'(GAP_CYC - 1);
  localparam logic [CNT_W-1:0] B_L    = CNT_W'(B_CYC - 1);
  localparam logic [CNT_W-1:0] ACQ_L  = CNT_W'(ACQ_CYC - 1);

  phase_e           state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last, go_edge, go_level, start_ok;

  assign last     = (cnt_q == '0);
  assign go_edge  = fall_i && (state_q == ST_IDLE);
  // level start only at the end of acquisition in reduced-power mode
  assign go_level = (state_q == ST_ACQ) && last && low_pwr_i && low_i;
  assign start_ok = !abort_i && !pwr_down_i && (go_edge || go_level);

  always_comb begin
    state_d = state_q;
    cnt_d   = last ? cnt_q : cnt_q - 1'b1;
    unique case (state_q)
      ST_IDLE: if (start_ok) begin
        state_d = ST_CONV_A;
        cnt_d   = low_pwr_i ? A_LP_L : A_NM_L;
      end
      ST_CONV_A: if (last) begin
        state_d = ST_GAP;
        cnt_d   = GAP_L;
      end
      ST_GAP: if (last) begin
        state_d = ST_CONV_B;
        cnt_d   = B_L;
      end
      ST_CONV_B: if (last) begin
        state_d = ST_ACQ;
        cnt_d   = ACQ_L;
      end
      ST_ACQ: if (start_ok) begin
        state_d = ST_CONV_A;
        cnt_d   = A_LP_L;
      end else if (last) begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
    if (abort_i) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign capture_o = start_ok;
  assign a_done_o  = (state_q == ST_CONV_A) && last && !abort_i;
  assign b_done_o  = (state_q == ST_CONV_B) && last && !abort_i;
  assign busy_o    = (state_q == ST_CONV_A) || (state_q == ST_GAP) || (state_q == ST_CONV_B);
  assign eoc_o     = (state_q == ST_CONV_A) || (state_q == ST_CONV_B);

  // R1
  start_edge_go_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_i && state_q == ST_IDLE && !pwr_down_i && !abort_i |=> busy_o && eoc_o);
  // R2
  eoc_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |-> busy_o);
  // R2
  busy_ends_in_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) && !$past(abort_i) |-> $past(eoc_o));
  // R7
  rise_from_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(state_q == ST_IDLE || state_q == ST_ACQ));
  // R9
  abort_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> !busy_o && !eoc_o);
  // R10
  pwr_down_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_down_i && !busy_o |=> !busy_o);
endmodule

// File: rtl/dcs_result_gen.sv
module dcs_result_gen #(
  parameter int unsigned W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           capture_i,
  input  logic           a_done_i,
  input  logic           ld_i,
  input  logic           pair_sel_i,
  input  logic [W-1:0]   ain_a1_i,
  input  logic [W-1:0]   ain_a2_i,
  input  logic [W-1:0]   ain_b1_i,
  input  logic [W-1:0]   ain_b2_i,
  output logic [2*W-1:0] result_o,
  output logic           pair_o
);
  localparam int unsigned NCH = 2;

  logic [W-1:0] in_p1 [NCH];
  logic [W-1:0] in_p2 [NCH];
  logic [W-1:0] samp_q [NCH];
  logic [W-1:0] a_code_q;
  logic         pair_held_q;

  assign in_p1[0] = ain_a1_i;
  assign in_p1[1] = ain_b1_i;
  assign in_p2[0] = ain_a2_i;
  assign in_p2[1] = ain_b2_i;

  // track-and-hold per channel
  for (genvar ch = 0; ch < NCH; ch++) begin : g_hold
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        samp_q[ch] <= '0;
      else if (capture_i) samp_q[ch] <= pair_sel_i ? in_p2[ch] : in_p1[ch];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pair_held_q <= 1'b0;
      a_code_q    <= '0;
      result_o    <= '0;
      pair_o      <= 1'b0;
    end else begin
      if (capture_i) pair_held_q <= pair_sel_i;
      if (a_done_i)  a_code_q    <= samp_q[0];
      if (ld_i) begin
        result_o <= {a_code_q, samp_q[1]};
        pair_o   <= pair_held_q;
      end
    end
  end

  // R6
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> $stable(result_o) && $stable(pair_o));
endmodule

// File: rtl/dual_conv_seq.sv
module dual_conv_seq #(
  parameter int unsigned W        = 16,
  parameter int unsigned A_NM_CYC = 196,
  parameter int unsigned A_LP_CYC = 246,
  parameter int unsigned GAP_CYC  = 4,
  parameter int unsigned B_CYC    = 150,
  parameter int unsigned ACQ_CYC  = 50
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           abort_i,
  input  logic           pwr_down_i,
  input  logic           low_pwr_i,
  input  logic           start_ni,
  input  logic           pair_sel_i,
  input  logic [W-1:0]   ain_a1_i,
  input  logic [W-1:0]   ain_a2_i,
  input  logic [W-1:0]   ain_b1_i,
  input  logic [W-1:0]   ain_b2_i,
  output logic           busy_o,
  output logic           eoc_o,
  output logic [2*W-1:0] result_o,
  output logic           pair_o
);
  logic fall, low, capture, a_done, b_done;

  dcs_start_qual u_start (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_ni(start_ni),
    .fall_o  (fall),
    .low_o   (low)
  );

  dcs_phase_ctrl #(
    .A_NM_CYC(A_NM_CYC),
    .A_LP_CYC(A_LP_CYC),
    .GAP_CYC (GAP_CYC),
    .B_CYC   (B_CYC),
    .ACQ_CYC (ACQ_CYC)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .abort_i   (abort_i),
    .pwr_down_i(pwr_down_i),
    .low_pwr_i (low_pwr_i),
    .fall_i    (fall),
    .low_i     (low),
    .capture_o (capture),
    .a_done_o  (a_done),
    .b_done_o  (b_done),
    .busy_o    (busy_o),
    .eoc_o     (eoc_o)
  );

  dcs_result_gen #(.W(W)) u_res (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture),
    .a_done_i  (a_done),
    .ld_i      (b_done),
    .pair_sel_i(pair_sel_i),
    .ain_a1_i  (ain_a1_i),
    .ain_a2_i  (ain_a2_i),
    .ain_b1_i  (ain_b1_i),
    .ain_b2_i  (ain_b2_i),
    .result_o  (result_o),
    .pair_o    (pair_o)
  );
endmodule

// File: tb/dual_conv_seq_tb_top.sv
module dual_conv_seq_tb_top;
  localparam int A_NM = 196;
  localparam int A_LP = 246;
  localparam int GAP  = 4;
  localparam int BC   = 150;
  localparam int ACQ  = 50;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        abort_i = 1'b0, pwr_down_i = 1'b0, low_pwr_i = 1'b0;
  logic        start_ni = 1'b1, pair_sel_i = 1'b0;
  logic [15:0] a1 = '0, a2 = '0, b1 = '0, b2 = '0;
  logic        busy_o, eoc_o, pair_o;
  logic [31:0] result_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  dual_conv_seq #(
    .W(16), .A_NM_CYC(A_NM), .A_LP_CYC(A_LP), .GAP_CYC(GAP), .B_CYC(BC), .ACQ_CYC(ACQ)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .abort_i(abort_i), .pwr_down_i(pwr_down_i),
    .low_pwr_i(low_pwr_i), .start_ni(start_ni), .pair_sel_i(pair_sel_i),
    .ain_a1_i(a1), .ain_a2_i(a2), .ain_b1_i(b1), .ain_b2_i(b2),
    .busy_o(busy_o), .eoc_o(eoc_o), .result_o(result_o), .pair_o(pair_o)
  );

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive a one-cycle low on start; returns at the first busy negedge
  task automatic kick();
    @(negedge clk) start_ni = 1'b0;
    @(negedge clk) start_ni = 1'b1;
  endtask

  task automatic measure(output int na, output int ng, output int nb, output bit moved);
    logic [31:0] r0;
    int ph, guard;
    r0 = result_o; na = 0; ng = 0; nb = 0; moved = 0; ph = 0; guard = 0;
    while (busy_o && guard < 5000) begin
      if (eoc_o) begin
        if (ph == 0) na++;
        else begin ph = 2; nb++; end
      end else if (ph < 2) begin
        ph = 1; ng++;
      end
      if (result_o !== r0) moved = 1;
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic idle_wait();
    repeat (ACQ + 5) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(busy_o == 0, "R11", "busy after reset", busy_o, 0);
    chk(eoc_o == 0, "R11", "eoc after reset", eoc_o, 0);
    chk(result_o == 0, "R11", "result after reset", result_o, 0);
    chk(pair_o == 0, "R11", "pair after reset", pair_o, 0);
  endtask

  task automatic t_normal();
    int na, ng, nb; bit mv;
    a1 = 16'h1234; b1 = 16'hABCD; a2 = 16'h0F0F; b2 = 16'hF0F0;
    pair_sel_i = 0; low_pwr_i = 0;
    kick();
    chk(busy_o == 1, "R1", "busy after edge", busy_o, 1);
    chk(eoc_o == 1, "R1", "eoc after edge", eoc_o, 1);
    measure(na, ng, nb, mv);
    chk(na == A_NM, "R3", "normal A length", na, A_NM);
    chk(ng == GAP, "R2", "gap length", ng, GAP);
    chk(nb == BC, "R2", "B length", nb, BC);
    chk(eoc_o == 0, "R2", "eoc low after", eoc_o, 0);
    chk(!mv, "R6", "result moved while busy", mv, 0);
    chk(result_o == {a1, b1}, "R4", "pair1 result", result_o, {a1, b1});
    chk(pair_o == 0, "R4", "pair flag", pair_o, 0);
    idle_wait();
  endtask

  task automatic t_lp_pair2();
    int na, ng, nb; bit mv;
    pair_sel_i = 1; low_pwr_i = 1;
    kick();
    low_pwr_i = 0; pair_sel_i = 0;
    measure(na, ng, nb, mv);
    chk(na == A_LP, "R3", "low-power A length", na, A_LP);
    chk(ng + nb == GAP + BC, "R2", "gap+B length", ng + nb, GAP + BC);
    chk(!mv, "R6", "result moved while busy", mv, 0);
    chk(result_o == {a2, b2}, "R4", "pair2 result", result_o, {a2, b2});
    chk(pair_o == 1, "R4", "pair flag", pair_o, 1);
    idle_wait();
  endtask

  task automatic t_hold();
    int na, ng, nb; bit mv;
    logic [31:0] exp;
    a1 = 16'h2468; b1 = 16'h1357; pair_sel_i = 0;
    exp = {a1, b1};
    kick();
    a1 = 16'h5555; b1 = 16'h6666; pair_sel_i = 1;
    measure(na, ng, nb, mv);
    chk(!mv, "R6", "result moved while busy", mv, 0);
    chk(result_o == exp, "R5", "frozen samples", result_o, exp);
    chk(pair_o == 0, "R5", "frozen pair", pair_o, 0);
    pair_sel_i = 0;
    idle_wait();
  endtask

  task automatic t_ignore();
    int n, hi;
    low_pwr_i = 0;
    kick();
    n = 0;
    while (busy_o && n < 5000) begin
      n++;
      if (n == 30) start_ni = 0;
      if (n == 31) start_ni = 1;
      @(negedge clk);
    end
    chk(n == A_NM + GAP + BC, "R7", "busy length with edge in busy", n, A_NM + GAP + BC);
    repeat (5) @(negedge clk);
    start_ni = 0;
    @(negedge clk) start_ni = 1;
    hi = 0;
    repeat (ACQ + 10) begin
      if (busy_o) hi++;
      @(negedge clk);
    end
    chk(hi == 0, "R7", "edge in acquisition started conversion", hi, 0);
  endtask

  task automatic t_level();
    int na, ng, nb, n, hi; bit mv;
    low_pwr_i = 1;
    @(negedge clk) start_ni = 0;
    @(negedge clk);
    measure(na, ng, nb, mv);
    n = 0;
    while (!busy_o && n < 500) begin n++; @(negedge clk); end
    chk(n == ACQ, "R8", "low-power level restart gap", n, ACQ);
    start_ni = 1;
    measure(na, ng, nb, mv);
    chk(na == A_LP, "R8", "restarted A length", na, A_LP);
    idle_wait();
    low_pwr_i = 0;
    @(negedge clk) start_ni = 0;
    @(negedge clk);
    measure(na, ng, nb, mv);
    hi = 0;
    repeat (ACQ + 20) begin
      if (busy_o) hi++;
      @(negedge clk);
    end
    chk(hi == 0, "R8", "normal mode held low restarted", hi, 0);
    start_ni = 1;
    idle_wait();
  endtask

  task automatic t_abort();
    int na, ng, nb; bit mv;
    logic [31:0] r;
    a1 = 16'h7777; b1 = 16'h8888; pair_sel_i = 0;
    r = result_o;
    kick();
    repeat (40) @(negedge clk);
    abort_i = 1;
    @(negedge clk) abort_i = 0;
    chk(busy_o == 0, "R9", "busy after abort", busy_o, 0);
    chk(eoc_o == 0, "R9", "eoc after abort", eoc_o, 0);
    chk(result_o == r, "R9", "result kept on abort", result_o, r);
    repeat (5) @(negedge clk);
    kick();
    chk(busy_o == 1, "R9", "start after abort", busy_o, 1);
    measure(na, ng, nb, mv);
    chk(result_o == {a1, b1}, "R9", "result after restart", result_o, {a1, b1});
    idle_wait();
  endtask

  task automatic t_pwrdown();
    int na, ng, nb, hi; bit mv;
    logic [31:0] r;
    a1 = 16'h0101; b1 = 16'hFEFE;
    kick();
    repeat (10) @(negedge clk);
    pwr_down_i = 1;
    measure(na, ng, nb, mv);
    chk(na + ng + nb == A_NM + GAP + BC - 10, "R10", "running conversion length",
        na + ng + nb, A_NM + GAP + BC - 10);
    chk(result_o == {a1, b1}, "R10", "result loaded in power-down", result_o, {a1, b1});
    idle_wait();
    r = result_o;
    kick();
    hi = 0;
    repeat (10) begin
      if (busy_o) hi++;
      @(negedge clk);
    end
    chk(hi == 0, "R10", "start in power-down", hi, 0);
    chk(result_o == r, "R10", "result unchanged in power-down", result_o, r);
    pwr_down_i = 0;
    idle_wait();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog (all R): actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    t_reset();
    t_normal();
    t_lp_pair2();
    t_hold();
    t_ignore();
    t_level();
    t_abort();
    t_pwrdown();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule